// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Configuration Lock

This block is a memory-mapped watchdog with two escalation levels that share one up-counter. The counter advances by one on each qualifying pulse of a slow tick-enable input (nominally a 200 kHz time base, so one second of enabled time adds 200000). When the counter reaches the first threshold, a clearable interrupt is raised to warn software. When it reaches the second threshold, the block emits a one-cycle reset request. The same event returns all of the block's own registers to their reset state. The system reset itself and the interrupt controller sit outside the block.

Software controls the block through a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. It can set the enable and pause-in-sleep controls, both thresholds and the count, and it can clear the interrupt. A one-way lock bit freezes the control word and both thresholds. Count writes are still accepted while the lock is set, so software can keep petting the watchdog. A sleep input stops counting when pause-in-sleep is selected. Several addresses belong to features this block does not provide. They read as zero and drop writes.

Top module: `dual_stage_wdog`

## Requirements
- R1: After reset, every register reads 0 except the lock register at byte offset 0x10, which reads 1. The interrupt and reset-request outputs are low.
- R2: Writing a value with bit 0 clear to offset 0x10 while it reads 1 makes it read 0. Once it reads 0, writing 1 leaves it at 0 until the next reset.
- R3: While offset 0x10 reads 0, writes to the control word (0x14), the warning threshold (0x18) and the reset threshold (0x1C) leave those registers unchanged. Writes to the count (0x20) still take effect.
- R4: In the control word, bit 0 is enable and bit 1 is pause-in-sleep. Only those two bits are stored, so writing all ones reads back 3. While enable is 0, the count holds its value regardless of ticks.
- R5: While enable is 1, each cycle with the tick input high adds exactly one to the count. The count holds in cycles without a tick.
- R6: The count saturates at all ones and never wraps to zero on a tick.
- R7: When pause-in-sleep is 1 and the sleep input is high, ticks are ignored. When pause-in-sleep is 0, the sleep input has no effect.
- R8: On a counted tick whose new count is at or above the warning threshold, bit 1 of the interrupt state (offset 0x24) is set and the interrupt output goes high. Bit 0 of that register always reads 0.
- R9: Writing a 1 to bit 1 of offset 0x24 clears that bit and lowers the interrupt, while writing 0 there has no effect. The interrupt is raised again on the next counted tick if the count is still at or above the warning threshold.
- R10: On a counted tick whose new count is at or above the reset threshold, the reset-request output is high for exactly one cycle. All registers, including the lock, return to their reset values at the same clock edge.
- R11: Offsets 0x00, 0x04, 0x08, 0x0C, 0x28 and 0x2C read as zero, and writes to them change no register.
- R12: A count write in the same cycle as a tick stores the written value with no increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base enable pulse |
| sleep_i | input | 1 | High while the system is asleep |
| bus_addr_i | input | ADDR_W (6) | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data for the addressed register |
| bark_irq_o | output | 1 | Warning interrupt, level |
| bite_req_o | output | 1 | Reset request, one-cycle pulse |

## Verification
A wrong count shows up as a wrong read of offset 0x20 after the next tick. It also moves the warning or the reset request by one or more ticks, which the interrupt or reset-request pin shows on the cycle after that tick. A lock or control register holding the wrong value shows up on the next read-back, or as counting that fails to stop or start on the following tick. Because the reset request clears every register, a missed or extra soft clear is visible on the very next read of any register, most clearly as a lock that reads 1 again.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

   // word indices (byte offset / 4) of the implemented registers
   localparam int unsigned IDX_LOCK  = 4;
   localparam int unsigned IDX_CTRL  = 5;
   localparam int unsigned IDX_WARN  = 6;
   localparam int unsigned IDX_FATAL = 7;
   localparam int unsigned IDX_COUNT = 8;
   localparam int unsigned IDX_INTR  = 9;

   // bit of the interrupt state register that carries the warning
   localparam int unsigned WARN_BIT = 1;

   // number of escalation stages sharing the counter
   localparam int unsigned NUM_STAGES = 2;
   localparam int unsigned STAGE_WARN  = 0;
   localparam int unsigned STAGE_FATAL = 1;

   typedef struct packed {
      logic pause_sleep;
      logic enable;
   } ctrl_t;

endpackage

// File: rtl/dsw_regfile.sv
module dsw_regfile #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 6
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                soft_clr_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic                bus_we_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   input  logic [DATA_W-1:0]   count_i,
   input  logic                warn_state_i,
   output logic                lock_o,
   output dsw_pkg::ctrl_t      ctrl_o,
   output logic [DATA_W-1:0]   warn_thr_o,
   output logic [DATA_W-1:0]   fatal_thr_o,
   output logic                cnt_we_o,
   output logic                intr_clr_o,
   output logic [DATA_W-1:0]   rdata_o
);
   import dsw_pkg::*;

   localparam int unsigned WIDX_W = ADDR_W - 2;
   localparam int unsigned NSEL   = 6;
   localparam int unsigned SEL_LOCK = 0, SEL_CTRL = 1, SEL_WARN = 2,
                           SEL_FATAL = 3, SEL_COUNT = 4, SEL_INTR = 5;

   logic [WIDX_W-1:0] widx;
   logic [NSEL-1:0]   hit;
   logic [NSEL-1:0]   wr;

   assign widx = bus_addr_i[ADDR_W-1:2];

   // one decoder per implemented word
   generate
      for (genvar s = 0; s < NSEL; s++) begin : g_dec
         localparam int unsigned IDX = (s == SEL_LOCK)  ? IDX_LOCK  :
                                       (s == SEL_CTRL)  ? IDX_CTRL  :
                                       (s == SEL_WARN)  ? IDX_WARN  :
                                       (s == SEL_FATAL) ? IDX_FATAL :
                                       (s == SEL_COUNT) ? IDX_COUNT : IDX_INTR;
         assign hit[s] = (widx == WIDX_W'(IDX));
         assign wr[s]  = bus_we_i & hit[s];
      end
   endgenerate

   logic              lock_q;
   ctrl_t             ctrl_q;
   logic [DATA_W-1:0] warn_q;
   logic [DATA_W-1:0] fatal_q;

   // lock: reset to 1, cleared only by writing bit0 = 0
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               lock_q <= 1'b1;
      else if (soft_clr_i)                       lock_q <= 1'b1;
      else if (wr[SEL_LOCK] && !bus_wdata_i[0])  lock_q <= 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q  <= '0;
         warn_q  <= '0;
         fatal_q <= '0;
      end else if (soft_clr_i) begin
         ctrl_q  <= '0;
         warn_q  <= '0;
         fatal_q <= '0;
      end else if (lock_q) begin
         if (wr[SEL_CTRL])  ctrl_q  <= ctrl_t'(bus_wdata_i[1:0]);
         if (wr[SEL_WARN])  warn_q  <= bus_wdata_i;
         if (wr[SEL_FATAL]) fatal_q <= bus_wdata_i;
      end
   end

   assign lock_o      = lock_q;
   assign ctrl_o      = ctrl_q;
   assign warn_thr_o  = warn_q;
   assign fatal_thr_o = fatal_q;
   assign cnt_we_o    = wr[SEL_COUNT];
   assign intr_clr_o  = wr[SEL_INTR] & bus_wdata_i[WARN_BIT];

   always_comb begin
      rdata_o = '0;
      if (hit[SEL_LOCK])  rdata_o = DATA_W'(lock_q);
      if (hit[SEL_CTRL])  rdata_o = DATA_W'({ctrl_q.pause_sleep, ctrl_q.enable});
      if (hit[SEL_WARN])  rdata_o = warn_q;
      if (hit[SEL_FATAL]) rdata_o = fatal_q;
      if (hit[SEL_COUNT]) rdata_o = count_i;
      if (hit[SEL_INTR])  rdata_o = DATA_W'({warn_state_i, 1'b0});
   end

endmodule

// File: rtl/dsw_counter.sv
module dsw_counter #(
   parameter int unsigned DATA_W = 32
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                soft_clr_i,
   input  logic                tick_i,
   input  logic                sleep_i,
   input  dsw_pkg::ctrl_t      ctrl_i,
   input  logic                cnt_we_i,
   input  logic [DATA_W-1:0]   cnt_wdata_i,
   output logic [DATA_W-1:0]   count_o,
   output logic [DATA_W-1:0]   next_o,
   output logic                eval_o
);
   localparam logic [DATA_W-1:0] CNT_MAX = '1;

   logic              qual_tick;
   logic [DATA_W-1:0] count_q;
   logic [DATA_W-1:0] inc;

   assign qual_tick = tick_i & ctrl_i.enable & ~(ctrl_i.pause_sleep & sleep_i);
   assign inc       = (count_q == CNT_MAX) ? count_q : count_q + DATA_W'(1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          count_q <= '0;
      else if (soft_clr_i)  count_q <= '0;
      else if (cnt_we_i)    count_q <= cnt_wdata_i;
      else if (qual_tick)   count_q <= inc;
   end

   assign count_o = count_q;
   assign next_o  = inc;
   // comparisons only on a counted tick that is not overridden by a write
   assign eval_o  = qual_tick & ~cnt_we_i;

endmodule

// File: rtl/dsw_stage_cmp.sv
module dsw_stage_cmp #(
   parameter int unsigned DATA_W = 32
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                eval_i,
   input  logic [DATA_W-1:0]   next_i,
   input  logic [DATA_W-1:0]   warn_thr_i,
   input  logic [DATA_W-1:0]   fatal_thr_i,
   input  logic                intr_clr_i,
   output logic                fatal_now_o,
   output logic                warn_q_o,
   output logic                fatal_q_o
);
   import dsw_pkg::*;

   logic [DATA_W-1:0]     thr [NUM_STAGES];
   logic [NUM_STAGES-1:0] reach;

   assign thr[STAGE_WARN]  = warn_thr_i;
   assign thr[STAGE_FATAL] = fatal_thr_i;

   generate
      for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
         assign reach[i] = eval_i & (next_i >= thr[i]);
      end
   endgenerate

   assign fatal_now_o = reach[STAGE_FATAL];

   logic warn_q, fatal_q;

   // a new warning event wins over a clear in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  warn_q <= 1'b0;
      else if (reach[STAGE_FATAL])  warn_q <= 1'b0;
      else if (reach[STAGE_WARN])   warn_q <= 1'b1;
      else if (intr_clr_i)          warn_q <= 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fatal_q <= 1'b0;
      else         fatal_q <= reach[STAGE_FATAL];
   end

   assign warn_q_o  = warn_q;
   assign fatal_q_o = fatal_q;

endmodule

// File: rtl/dual_stage_wdog.sv
module dual_stage_wdog #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 6
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               tick_i,
   input  logic               sleep_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic               bus_we_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   output logic               bark_irq_o,
   output logic               bite_req_o
);
   generate
      if (DATA_W < 8 || DATA_W > 64) begin : g_bad_data_w
         $error("dual_stage_wdog: DATA_W must lie in 8..64");
      end
      if (ADDR_W < 6) begin : g_bad_addr_w
         $error("dual_stage_wdog: ADDR_W must be at least 6");
      end
   endgenerate

   logic              soft_clr;
   logic              lock_q;
   dsw_pkg::ctrl_t    ctrl;
   logic [DATA_W-1:0] warn_thr, fatal_thr;
   logic              cnt_we, intr_clr;
   logic [DATA_W-1:0] count_q, next_cnt;
   logic              eval_tick;
   logic              warn_q, fatal_q;

   dsw_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .soft_clr_i   (soft_clr),
      .bus_addr_i   (bus_addr_i),
      .bus_we_i     (bus_we_i),
      .bus_wdata_i  (bus_wdata_i),
      .count_i      (count_q),
      .warn_state_i (warn_q),
      .lock_o       (lock_q),
      .ctrl_o       (ctrl),
      .warn_thr_o   (warn_thr),
      .fatal_thr_o  (fatal_thr),
      .cnt_we_o     (cnt_we),
      .intr_clr_o   (intr_clr),
      .rdata_o      (bus_rdata_o)
   );

   dsw_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .soft_clr_i  (soft_clr),
      .tick_i      (tick_i),
      .sleep_i     (sleep_i),
      .ctrl_i      (ctrl),
      .cnt_we_i    (cnt_we),
      .cnt_wdata_i (bus_wdata_i),
      .count_o     (count_q),
      .next_o      (next_cnt),
      .eval_o      (eval_tick)
   );

   dsw_stage_cmp #(.DATA_W(DATA_W)) u_cmp (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .eval_i      (eval_tick),
      .next_i      (next_cnt),
      .warn_thr_i  (warn_thr),
      .fatal_thr_i (fatal_thr),
      .intr_clr_i  (intr_clr),
      .fatal_now_o (soft_clr),
      .warn_q_o    (warn_q),
      .fatal_q_o   (fatal_q)
   );

   assign bark_irq_o = warn_q;
   assign bite_req_o = fatal_q;

endmodule

// File: rtl/dsw_checker.sv
module dsw_checker #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              eval_tick,
   input logic              cnt_we,
   input logic              enable,
   input logic [DATA_W-1:0] count_q,
   input logic              lock_q,
   input logic [DATA_W-1:0] warn_thr,
   input logic              bark_irq_o,
   input logic              bite_req_o
);
   localparam logic [DATA_W-1:0] CMAX = '1;

   // R10: reset request lasts one cycle
   a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bite_req_o |=> !bite_req_o);

   // R10: the same edge that raises the request clears the warning
   a_r10_clears_warning: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bite_req_o |-> !bark_irq_o && lock_q);

   // R2: lock never returns to 1 except through a soft clear
   a_r2_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lock_q |=> !lock_q || bite_req_o);

   // R3: thresholds frozen while locked
   a_r3_locked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lock_q |=> $stable(warn_thr) || bite_req_o);

   // R4: no counting while disabled
   a_r4_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!enable && !cnt_we) |=> $stable(count_q));

   // R5: one step per counted tick
   a_r5_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_tick && count_q != CMAX) |=>
         (count_q == $past(count_q) + DATA_W'(1)) || bite_req_o);

   // R6: no wrap at the top
   a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (count_q == CMAX && !cnt_we) |=> (count_q == CMAX) || bite_req_o);

   // R8: warning only rises after a counted tick
   a_r8_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(bark_irq_o) |-> $past(eval_tick));

endmodule

bind dual_stage_wdog dsw_checker #(.DATA_W(DATA_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .eval_tick  (eval_tick),
   .cnt_we     (cnt_we),
   .enable     (ctrl.enable),
   .count_q    (count_q),
   .lock_q     (lock_q),
   .warn_thr   (warn_thr),
   .bark_irq_o (bark_irq_o),
   .bite_req_o (bite_req_o)
);

// File: tb/sim_dual_stage_wdog.sv
module sim_dual_stage_wdog;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int AW = 6;

   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_SL = 2'd3;
   localparam int NV = 63;

   // {req, op, addr, data, expected}
   localparam logic [75:0] VEC [NV] = '{
      {4'd1,  OP_RD, 6'h10, 32'h0,        32'h1},        // R1
      {4'd1,  OP_RD, 6'h14, 32'h0,        32'h0},        // R1
      {4'd1,  OP_RD, 6'h18, 32'h0,        32'h0},        // R1
      {4'd1,  OP_RD, 6'h1C, 32'h0,        32'h0},        // R1
      {4'd1,  OP_RD, 6'h20, 32'h0,        32'h0},        // R1
      {4'd1,  OP_RD, 6'h24, 32'h0,        32'h0},        // R1
      {4'd4,  OP_WR, 6'h14, 32'hFFFFFFFF, 32'h0},        // R4
      {4'd4,  OP_RD, 6'h14, 32'h0,        32'h3},        // R4 two bits stored
      {4'd4,  OP_WR, 6'h14, 32'h0,        32'h0},
      {4'd8,  OP_WR, 6'h18, 32'h5,        32'h0},
      {4'd10, OP_WR, 6'h1C, 32'h64,       32'h0},
      {4'd5,  OP_WR, 6'h20, 32'h2,        32'h0},
      {4'd4,  OP_TK, 6'h00, 32'h0,        32'h0},        // R4 disabled tick
      {4'd4,  OP_RD, 6'h20, 32'h0,        32'h2},
      {4'd5,  OP_WR, 6'h14, 32'h1,        32'h0},
      {4'd5,  OP_TK, 6'h00, 32'h0,        32'h0},
      {4'd5,  OP_TK, 6'h00, 32'h0,        32'h0},
      {4'd5,  OP_RD, 6'h20, 32'h0,        32'h4},        // R5
      {4'd8,  OP_RD, 6'h24, 32'h0,        32'h0},        // R8 below threshold
      {4'd8,  OP_TK, 6'h00, 32'h0,        32'h0},
      {4'd8,  OP_RD, 6'h24, 32'h0,        32'h2},        // R8 set at 5
      {4'd9,  OP_WR, 6'h24, 32'h1,        32'h0},
      {4'd9,  OP_RD, 6'h24, 32'h0,        32'h2},        // R9 bit1 clear write only
      {4'd9,  OP_WR, 6'h24, 32'h2,        32'h0},
      {4'd9,  OP_RD, 6'h24, 32'h0,        32'h0},        // R9 cleared
      {4'd9,  OP_TK, 6'h00, 32'h0,        32'h0},
      {4'd9,  OP_RD, 6'h24, 32'h0,        32'h2},        // R9 refire
      {4'd9,  OP_WR, 6'h24, 32'h2,        32'h0},
      {4'd9,  OP_WR, 6'h20, 32'h0,        32'h0},
      {4'd9,  OP_TK, 6'h00, 32'h0,        32'h0},
      {4'd9,  OP_RD, 6'h24, 32'h0,        32'h0},        // R9 no refire below
      {4'd7,  OP_WR, 6'h14, 32'h3,        32'h0},
      {4'd7,  OP_SL, 6'h00, 32'h1,        32'h0},
      {4'd7,  OP_TK, 6'h00, 32'h0,        32'h0},
      {4'd7,  OP_RD, 6'h20, 32'h0,        32'h1},        // R7 paused
      {4'd7,  OP_WR, 6'h14, 32'h1,        32'h0},
      {4'd7,  OP_TK, 6'h00, 32'h0,        32'h0},
      {4'd7,  OP_RD, 6'h20, 32'h0,        32'h2},        // R7 sleep ignored
      {4'd7,  OP_SL, 6'h00, 32'h0,        32'h0},
      {4'd11, OP_WR, 6'h00, 32'hFFFFFFFF, 32'h0},
      {4'd11, OP_WR, 6'h0C, 32'hFFFFFFFF, 32'h0},
      {4'd11, OP_WR, 6'h28, 32'hFFFFFFFF, 32'h0},
      {4'd11, OP_WR, 6'h2C, 32'hFFFFFFFF, 32'h0},
      {4'd11, OP_RD, 6'h00, 32'h0,        32'h0},        // R11
      {4'd11, OP_RD, 6'h04, 32'h0,        32'h0},
      {4'd11, OP_RD, 6'h08, 32'h0,        32'h0},
      {4'd11, OP_RD, 6'h0C, 32'h0,        32'h0},
      {4'd11, OP_RD, 6'h28, 32'h0,        32'h0},
      {4'd11, OP_RD, 6'h2C, 32'h0,        32'h0},
      {4'd11, OP_RD, 6'h20, 32'h0,        32'h2},
      {4'd11, OP_RD, 6'h18, 32'h0,        32'h5},
      {4'd2,  OP_WR, 6'h10, 32'h0,        32'h0},
      {4'd2,  OP_RD, 6'h10, 32'h0,        32'h0},        // R2 cleared
      {4'd2,  OP_WR, 6'h10, 32'h1,        32'h0},
      {4'd2,  OP_RD, 6'h10, 32'h0,        32'h0},        // R2 sticky
      {4'd3,  OP_WR, 6'h14, 32'h0,        32'h0},
      {4'd3,  OP_RD, 6'h14, 32'h0,        32'h1},        // R3
      {4'd3,  OP_WR, 6'h18, 32'h9,        32'h0},
      {4'd3,  OP_RD, 6'h18, 32'h0,        32'h5},        // R3
      {4'd3,  OP_WR, 6'h1C, 32'h9,        32'h0},
      {4'd3,  OP_RD, 6'h1C, 32'h0,        32'h64},       // R3
      {4'd3,  OP_WR, 6'h20, 32'h7,        32'h0},
      {4'd3,  OP_RD, 6'h20, 32'h0,        32'h7}         // R3 pet allowed
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          sleep = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          we = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          bark, bite;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_stage_wdog #(.DATA_W(DW), .ADDR_W(AW)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sleep_i(sleep),
      .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .bark_irq_o(bark), .bite_req_o(bite)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick = 1'b0; sleep = 1'b0; we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      addr = a; we = 1'b0;
      #1 d = rdata;
   endtask

   // returns the reset-request level seen on the cycle after the tick edge
   task automatic pulse_tick(output logic req_seen);
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      req_seen = bite;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [DW-1:0] v;
      logic          b;
      do_reset();
      check("R1 bark", DW'(bark), 0);
      check("R1 bite", DW'(bite), 0);

      for (int i = 0; i < NV; i++) begin
         logic [3:0]    rq;
         logic [1:0]    op;
         logic [AW-1:0] a;
         logic [DW-1:0] d, e;
         {rq, op, a, d, e} = VEC[i];
         case (op)
            OP_WR: bus_wr(a, d);
            OP_TK: pulse_tick(b);
            OP_SL: begin @(negedge clk); sleep = d[0]; end
            default: begin
               bus_rd(a, v);
               check($sformatf("R%0d vec%0d", rq, i), v, e);
            end
         endcase
      end

      // R8 / R10: warning then reset request
      do_reset();
      bus_wr(6'h18, 32'd3);
      bus_wr(6'h1C, 32'd4);
      bus_wr(6'h14, 32'd1);
      bus_wr(6'h20, 32'd2);
      bus_wr(6'h10, 32'd0);
      pulse_tick(b);
      check("R8 irq high", DW'(bark), 1);
      check("R8 no request", DW'(b), 0);
      pulse_tick(b);
      check("R10 request raised", DW'(b), 1);
      check("R10 irq cleared", DW'(bark), 0);
      @(negedge clk);
      check("R10 one cycle", DW'(bite), 0);
      bus_rd(6'h10, v); check("R10 lock back", v, 1);
      bus_rd(6'h14, v); check("R10 ctrl", v, 0);
      bus_rd(6'h18, v); check("R10 warn thr", v, 0);
      bus_rd(6'h1C, v); check("R10 fatal thr", v, 0);
      bus_rd(6'h20, v); check("R10 count", v, 0);
      bus_rd(6'h24, v); check("R10 intr", v, 0);

      // R6: at all ones a tick saturates and hits an all-ones reset threshold
      bus_wr(6'h1C, 32'hFFFFFFFF);
      bus_wr(6'h18, 32'hFFFFFFFF);
      bus_wr(6'h20, 32'hFFFFFFFF);
      bus_wr(6'h14, 32'd1);
      pulse_tick(b);
      check("R6 saturate", DW'(b), 1);

      // R12: count write and tick together
      bus_wr(6'h14, 32'd1);
      bus_wr(6'h18, 32'h16);
      bus_wr(6'h1C, 32'h2000);
      bus_wr(6'h20, 32'd10);
      @(negedge clk);
      addr = 6'h20; wdata = 32'd20; we = 1'b1; tick = 1'b1;
      @(negedge clk);
      we = 1'b0; tick = 1'b0;
      bus_rd(6'h20, v); check("R12 write wins", v, 20);
      pulse_tick(b);
      bus_rd(6'h20, v); check("R5 step", v, 21);
      check("R8 below", DW'(bark), 0);
      pulse_tick(b);
      check("R8 irq at threshold", DW'(bark), 1);
      bus_wr(6'h24, 32'h2);
      check("R9 irq lowered", DW'(bark), 0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule